// File: doc/BRIEF.md
# Cross-Domain Exception Context Sequencer

This block saves and restores processor register context when an exception is taken or returned from. It is driven by an exception request that carries the domain of the handler, by the present security domain that the block holds, and by a return request. On entry it copies registers from the register file into the stack of the interrupted domain, one word per cycle. On return it copies them back. It also owns one stack pointer for each domain.

An exception that stays in the same domain, or that starts from non-secure code, saves the usual eight-word frame. If secure code is interrupted by a handler in the non-secure domain, the block saves all sixteen words. It then clears R0 to R12 in a single cycle before the handler starts, so the handler cannot read secure values. Entry produces a two-bit return code. Software hands this code back with the return request, and the block uses it to choose the frame size and the stack to pop from.

The register file is modelled outside the block:
- It has a combinational read port, a write port and a bulk clear.
- The stack memory has a synchronous read with one cycle of latency.

Top module: `secure_ctx_seq`

## Requirements
- R1: An exception with a partial frame (the running domain is non-secure, or the target is secure) writes 8 words to the stack of the running domain. The words go to base address SP-8 and upward, one per cycle, with mem_wdata equal to rf_rd_data of rf_rd_idx. Slot k holds register index k for k<4; slots 4..7 hold indices 12, 14, 15 and 16 (16 is the status word). busy stays high for 8 cycles.
- R2: An exception with target non-secure (exc_to_sec=0) taken while secure (sec_state=1) writes 16 words to the secure stack. Slots 0..7 are as in R1 and slots 8..15 hold R4..R11. busy stays high for 17 cycles.
- R3: After a 16-word frame, rf_clr is asserted for exactly one cycle and zeroes R0..R12, leaving R13..R16 as they were. An 8-word frame clears no register.
- R4: exc_ret_val holds the entry's return code: bit0 is 1 for a 16-word frame, and bit1 is 1 if the interrupted domain was secure.
- R5: On entry, the stack pointer of the interrupted domain drops by the frame size, and the other domain's pointer is left as it was. Reset values are SP_S_INIT for the secure domain and SP_NS_INIT for the non-secure domain.
- R6: A return with ret_code in the R4 encoding reads the frame from the current pointer of the domain in bit1, upward. It writes each slot back to its register one cycle after the read and then raises that pointer by the frame size. Registers not in the frame are left untouched. busy stays high for 9 cycles (8-word frame) or 17 cycles (16-word frame).
- R7: sec_state resets to 1 (secure). It changes only at the end of a sequence: to exc_to_sec after entry, and to ret_code[1] after return.
- R8: Requests arriving while busy is high are ignored. If exc_req and ret_req arrive together while idle, the exception is served.
- R9: After reset, busy, rf_clr, rf_wr_en, mem_wr_en and mem_rd_en are all 0, and they stay 0 whenever busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Exception request, sampled while idle |
| exc_to_sec | input | 1 | Domain of the handler, 1 = secure |
| ret_req | input | 1 | Exception return request, sampled while idle |
| ret_code | input | 2 | Return code handed back from entry |
| sec_state | output | 1 | Present security domain, 1 = secure |
| busy | output | 1 | A save or restore sequence is running |
| exc_ret_val | output | 2 | Return code produced by the last entry |
| rf_rd_idx | output | IDX_W | Register file read index |
| rf_rd_data | input | DW | Register file read data (combinational) |
| rf_wr_en | output | 1 | Register file write strobe |
| rf_wr_idx | output | IDX_W | Register file write index |
| rf_wr_data | output | DW | Register file write data |
| rf_clr | output | 1 | Clear R0..R12 |
| mem_wr_en | output | 1 | Stack memory write strobe |
| mem_rd_en | output | 1 | Stack memory read strobe |
| mem_addr | output | AW | Stack memory word address |
| mem_wdata | output | DW | Stack memory write data |
| mem_rdata | input | DW | Stack memory read data, one cycle after mem_rd_en |

## Verification
The assertions assume that the memory returns read data exactly one cycle after the read strobe. They also assume that ret_code is a value the block produced earlier, applied while the matching frame is the newest one on that stack. The bench holds a stack of outstanding return codes and only ever returns the newest one. It does not nest deeper than four levels, so frames never wrap the address space. Requests are driven away from the clock edge for one cycle each. The bench deliberately pulses requests during a busy sequence, to show they are ignored.

// File: rtl/ctx_seq_pkg.sv
package ctx_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH,
    ST_WIPE,
    ST_POP,
    ST_DRAIN
  } seq_state_t;

  localparam int PART_WORDS = 8;
  localparam int FULL_WORDS = 16;
  localparam int CNT_W      = $clog2(FULL_WORDS);
  localparam int REG_IP     = 12;
  localparam int REG_LR     = 14;
  localparam int REG_PC     = 15;
  localparam int REG_PSR    = 16;
endpackage

// File: rtl/ctx_slot_map.sv
module ctx_slot_map
  import ctx_seq_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [CNT_W-1:0] slot,
  output logic [IDX_W-1:0] reg_idx
);
  // Slots 0..3: R0..R3. Slots 4..7: R12, LR, PC, status. Slots 8..15: R4..R11.
  always_comb begin
    if (slot < CNT_W'(4)) begin
      reg_idx = IDX_W'(slot);
    end else if (slot < CNT_W'(PART_WORDS)) begin
      case (slot[1:0])
        2'd0:    reg_idx = IDX_W'(REG_IP);
        2'd1:    reg_idx = IDX_W'(REG_LR);
        2'd2:    reg_idx = IDX_W'(REG_PC);
        default: reg_idx = IDX_W'(REG_PSR);
      endcase
    end else begin
      reg_idx = IDX_W'(slot) - IDX_W'(4);
    end
  end
endmodule

// File: rtl/ctx_sp_bank.sv
module ctx_sp_bank #(
  parameter int          AW         = 10,
  parameter logic [AW-1:0] SP_S_INIT  = '0,
  parameter logic [AW-1:0] SP_NS_INIT = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_sec,
  output logic [AW-1:0] sp_out,
  input  logic          upd_en,
  input  logic [AW-1:0] upd_val
);
  logic [AW-1:0] sp_q [2];

  for (genvar g = 0; g < 2; g++) begin : g_dom
    localparam logic [AW-1:0] RV = (g == 1) ? SP_S_INIT : SP_NS_INIT;
    always_ff @(posedge clk) begin
      if (rst) begin
        sp_q[g] <= RV;
      end else if (upd_en && (sel_sec == 1'(g))) begin
        sp_q[g] <= upd_val;
      end
    end
  end

  assign sp_out = sp_q[sel_sec];
endmodule

// File: rtl/secure_ctx_seq.sv
module secure_ctx_seq
  import ctx_seq_pkg::*;
#(
  parameter int            AW         = 10,
  parameter int            DW         = 32,
  parameter int            IDX_W      = 5,
  parameter logic [AW-1:0] SP_S_INIT  = 10'h200,
  parameter logic [AW-1:0] SP_NS_INIT = 10'h3C0,
  parameter logic          RESET_SEC  = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             exc_req,
  input  logic             exc_to_sec,
  input  logic             ret_req,
  input  logic [1:0]       ret_code,
  output logic             sec_state,
  output logic             busy,
  output logic [1:0]       exc_ret_val,
  output logic [IDX_W-1:0] rf_rd_idx,
  input  logic [DW-1:0]    rf_rd_data,
  output logic             rf_wr_en,
  output logic [IDX_W-1:0] rf_wr_idx,
  output logic [DW-1:0]    rf_wr_data,
  output logic             rf_clr,
  output logic             mem_wr_en,
  output logic             mem_rd_en,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata
);
  seq_state_t       st;
  logic [CNT_W-1:0] cnt;
  logic             full_q;
  logic             dst_q;

  logic             idle;
  logic             full_new;
  logic             full_sel;
  logic [AW-1:0]    nwords;
  logic [CNT_W-1:0] last;
  logic             sp_sel;
  logic [AW-1:0]    sp_out;
  logic             sp_upd;
  logic [AW-1:0]    sp_nxt;
  logic [CNT_W-1:0] slot_n;
  logic [IDX_W-1:0] idx_n;
  logic [IDX_W-1:0] idx_c;

  assign idle     = (st == ST_IDLE);
  assign full_new = exc_req ? (sec_state & ~exc_to_sec) : ret_code[0];
  assign full_sel = idle ? full_new : full_q;
  assign nwords   = full_sel ? AW'(FULL_WORDS) : AW'(PART_WORDS);
  assign last     = full_q ? CNT_W'(FULL_WORDS - 1) : CNT_W'(PART_WORDS - 1);
  assign sp_sel   = idle ? (exc_req ? sec_state : ret_code[1]) : dst_q;
  assign sp_upd   = (idle && exc_req) || (st == ST_DRAIN);
  assign sp_nxt   = idle ? (sp_out - nwords) : (sp_out + nwords);
  assign slot_n   = idle ? '0 : cnt + CNT_W'(1);

  ctx_sp_bank #(
    .AW(AW), .SP_S_INIT(SP_S_INIT), .SP_NS_INIT(SP_NS_INIT)
  ) u_sp (
    .clk(clk), .rst(rst), .sel_sec(sp_sel), .sp_out(sp_out),
    .upd_en(sp_upd), .upd_val(sp_nxt)
  );

  ctx_slot_map #(.IDX_W(IDX_W)) u_map_nxt (.slot(slot_n), .reg_idx(idx_n));
  ctx_slot_map #(.IDX_W(IDX_W)) u_map_cur (.slot(cnt),    .reg_idx(idx_c));

  assign mem_wdata  = rf_rd_data;
  assign rf_wr_data = mem_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      cnt         <= '0;
      full_q      <= 1'b0;
      dst_q       <= 1'b0;
      sec_state   <= RESET_SEC;
      busy        <= 1'b0;
      exc_ret_val <= '0;
      rf_rd_idx   <= '0;
      rf_wr_en    <= 1'b0;
      rf_wr_idx   <= '0;
      rf_clr      <= 1'b0;
      mem_wr_en   <= 1'b0;
      mem_rd_en   <= 1'b0;
      mem_addr    <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (exc_req) begin
            st          <= ST_PUSH;
            cnt         <= '0;
            full_q      <= full_new;
            dst_q       <= exc_to_sec;
            busy        <= 1'b1;
            exc_ret_val <= {sec_state, full_new};
            mem_wr_en   <= 1'b1;
            mem_addr    <= sp_nxt;
            rf_rd_idx   <= idx_n;
          end else if (ret_req) begin
            st        <= ST_POP;
            cnt       <= '0;
            full_q    <= ret_code[0];
            dst_q     <= ret_code[1];
            busy      <= 1'b1;
            mem_rd_en <= 1'b1;
            mem_addr  <= sp_out;
          end
        end
        ST_PUSH: begin
          cnt <= cnt + CNT_W'(1);
          if (cnt == last) begin
            mem_wr_en <= 1'b0;
            if (full_q) begin
              st     <= ST_WIPE;
              rf_clr <= 1'b1;
            end else begin
              st        <= ST_IDLE;
              busy      <= 1'b0;
              sec_state <= dst_q;
            end
          end else begin
            mem_addr  <= mem_addr + AW'(1);
            rf_rd_idx <= idx_n;
          end
        end
        ST_WIPE: begin
          rf_clr    <= 1'b0;
          st        <= ST_IDLE;
          busy      <= 1'b0;
          sec_state <= dst_q;
        end
        ST_POP: begin
          cnt       <= cnt + CNT_W'(1);
          rf_wr_en  <= 1'b1;
          rf_wr_idx <= idx_c;
          if (cnt == last) begin
            mem_rd_en <= 1'b0;
            st        <= ST_DRAIN;
          end else begin
            mem_addr <= mem_addr + AW'(1);
          end
        end
        ST_DRAIN: begin
          rf_wr_en  <= 1'b0;
          st        <= ST_IDLE;
          busy      <= 1'b0;
          sec_state <= dst_q;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ctx_seq_checker.sv
module ctx_seq_checker #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          sec_state,
  input logic          rf_clr,
  input logic          rf_wr_en,
  input logic          mem_wr_en,
  input logic          mem_rd_en,
  input logic [AW-1:0] mem_addr
);
  a_r3_wipe_one_cycle: assert property (@(posedge clk) disable iff (rst)
    rf_clr |=> !rf_clr);

  a_r3_wipe_after_push: assert property (@(posedge clk) disable iff (rst)
    rf_clr |-> $past(mem_wr_en));

  a_r1_push_ascends: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_en && $past(mem_wr_en)) |-> (mem_addr == $past(mem_addr) + AW'(1)));

  a_r6_pop_ascends: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr == $past(mem_addr) + AW'(1)));

  a_r6_write_follows_read: assert property (@(posedge clk) disable iff (rst)
    rf_wr_en |-> $past(mem_rd_en));

  a_r7_state_at_end: assert property (@(posedge clk) disable iff (rst)
    (sec_state != $past(sec_state)) |-> ($past(busy) && !busy));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(mem_wr_en || mem_rd_en || rf_clr || rf_wr_en));

  a_r9_no_rw_overlap: assert property (@(posedge clk) disable iff (rst)
    !(mem_wr_en && mem_rd_en));
endmodule

bind secure_ctx_seq ctx_seq_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .sec_state(sec_state),
  .rf_clr(rf_clr), .rf_wr_en(rf_wr_en), .mem_wr_en(mem_wr_en),
  .mem_rd_en(mem_rd_en), .mem_addr(mem_addr)
);

// File: tb/sim_secure_ctx_seq.sv
`timescale 1ns/1ps
module sim_secure_ctx_seq;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int IDX_W = 5;
  localparam logic [AW-1:0] SPS  = 10'h200;
  localparam logic [AW-1:0] SPNS = 10'h3C0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic exc_req = 1'b0, exc_to_sec = 1'b0, ret_req = 1'b0;
  logic [1:0] ret_code = 2'b00;
  logic sec_state, busy;
  logic [1:0] exc_ret_val;
  logic [IDX_W-1:0] rf_rd_idx, rf_wr_idx;
  logic [DW-1:0] rf_rd_data, rf_wr_data, mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic rf_wr_en, rf_clr, mem_wr_en, mem_rd_en;
  logic [AW-1:0] mem_addr;

  logic [DW-1:0] rf [0:16];
  logic [DW-1:0] mem [0:(1<<AW)-1];

  always #5 clk = ~clk;

  secure_ctx_seq #(.AW(AW), .DW(DW), .IDX_W(IDX_W), .SP_S_INIT(SPS), .SP_NS_INIT(SPNS)) u0 (
    .clk(clk), .rst(rst), .exc_req(exc_req), .exc_to_sec(exc_to_sec),
    .ret_req(ret_req), .ret_code(ret_code), .sec_state(sec_state), .busy(busy),
    .exc_ret_val(exc_ret_val), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
    .rf_clr(rf_clr), .mem_wr_en(mem_wr_en), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  assign rf_rd_data = rf[rf_rd_idx];

  always @(posedge clk) begin
    if (rf_clr) begin
      for (int i = 0; i <= 12; i++) rf[i] <= '0;
    end else if (rf_wr_en) begin
      rf[rf_wr_idx] <= rf_wr_data;
    end
    if (mem_wr_en) mem[mem_addr] <= mem_wdata;
    if (mem_rd_en) mem_rdata <= mem[mem_addr];
  end

  int n_chk = 0, n_fail = 0;
  logic model_sec;
  logic [AW-1:0] m_sp_s, m_sp_ns;
  int depth = 0;
  logic [1:0] codes [0:3];
  logic [DW-1:0] snaps [0:3][0:16];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int bslot(input int k);
    if (k < 4) return k;
    case (k)
      4: return 12;
      5: return 14;
      6: return 15;
      7: return 16;
      default: return k - 4;
    endcase
  endfunction

  function automatic bit in_frame(input int r, input bit full);
    return (r != 13) && (full || r < 4 || r >= 12);
  endfunction

  task automatic scramble();
    for (int i = 0; i < 17; i++) rf[i] = $urandom;
  endtask

  task automatic take_exc(input bit tgt, input bit poke, input bit both);
    bit cur, full;
    int n, cyc, bad;
    logic [AW-1:0] base, a0;
    cur  = model_sec;
    full = cur && !tgt;
    n    = full ? 16 : 8;
    base = (cur ? m_sp_s : m_sp_ns) - AW'(n);
    for (int i = 0; i < 17; i++) snaps[depth][i] = rf[i];
    @(negedge clk);
    exc_to_sec = tgt; exc_req = 1'b1;
    ret_req = both; ret_code = 2'b11;
    @(negedge clk);
    exc_req = 1'b0; ret_req = 1'b0;
    a0 = mem_addr; cyc = 0;
    while (busy) begin
      cyc++;
      @(negedge clk);
      if (poke && cyc == 3) begin exc_req = 1'b1; ret_req = 1'b1; end
      else begin exc_req = 1'b0; ret_req = 1'b0; end
    end
    exc_req = 1'b0; ret_req = 1'b0;
    chk(cyc == (full ? 17 : 8), full ? "R2" : "R1", "entry busy cycles", cyc, full ? 17 : 8);
    chk(a0 == base, "R5", "frame base address", a0, base);
    bad = 0;
    for (int k = 0; k < n; k++) if (mem[base + AW'(k)] !== snaps[depth][bslot(k)]) bad++;
    chk(bad == 0, full ? "R2" : "R1", "stacked words wrong", bad, 0);
    bad = 0;
    for (int i = 0; i < 17; i++)
      if (rf[i] !== ((full && i <= 12) ? '0 : snaps[depth][i])) bad++;
    chk(bad == 0, "R3", "registers after entry wrong", bad, 0);
    chk(exc_ret_val == {cur, full}, "R4", "return code", exc_ret_val, {cur, full});
    chk(sec_state == tgt, both ? "R8" : "R7", "state after entry", sec_state, tgt);
    if (poke) begin
      repeat (3) @(negedge clk);
      chk(busy == 1'b0 && sec_state == tgt, "R8", "request during busy not ignored", busy, 0);
    end
    if (cur) m_sp_s = base; else m_sp_ns = base;
    codes[depth] = {cur, full};
    model_sec = tgt;
    depth++;
    scramble();
  endtask

  task automatic do_ret();
    int d, n, cyc, bad;
    bit full, dst;
    logic [AW-1:0] base, a0;
    logic [DW-1:0] pre [0:16];
    d = depth - 1;
    full = codes[d][0]; dst = codes[d][1];
    n = full ? 16 : 8;
    base = dst ? m_sp_s : m_sp_ns;
    for (int i = 0; i < 17; i++) pre[i] = rf[i];
    @(negedge clk);
    ret_code = codes[d]; ret_req = 1'b1;
    @(negedge clk);
    ret_req = 1'b0;
    a0 = mem_addr; cyc = 0;
    while (busy) begin cyc++; @(negedge clk); end
    chk(cyc == n + 1, "R6", "return busy cycles", cyc, n + 1);
    chk(a0 == base, "R6", "pop base address", a0, base);
    bad = 0;
    for (int i = 0; i < 17; i++)
      if (rf[i] !== (in_frame(i, full) ? snaps[d][i] : pre[i])) bad++;
    chk(bad == 0, "R6", "restored registers wrong", bad, 0);
    chk(sec_state == dst, "R7", "state after return", sec_state, dst);
    if (dst) m_sp_s = base + AW'(n); else m_sp_ns = base + AW'(n);
    model_sec = dst;
    depth--;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < (1 << AW); i++) mem[i] = $urandom;
    scramble();
    model_sec = 1'b1; m_sp_s = SPS; m_sp_ns = SPNS;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0 && rf_clr == 0 && rf_wr_en == 0 && mem_wr_en == 0 && mem_rd_en == 0,
        "R9", "strobes after reset", {busy, rf_clr, rf_wr_en, mem_wr_en, mem_rd_en}, 0);
    chk(sec_state == 1'b1, "R7", "reset domain", sec_state, 1);
    // secure to secure: partial frame
    take_exc(1'b1, 1'b0, 1'b0);
    do_ret();
    // secure to non-secure: full frame, wipe, then nesting on the non-secure stack
    take_exc(1'b0, 1'b0, 1'b0);
    take_exc(1'b0, 1'b0, 1'b0);
    take_exc(1'b1, 1'b0, 1'b0);
    do_ret(); do_ret(); do_ret();
    // requests during a busy sequence are ignored
    take_exc(1'b1, 1'b1, 1'b0);
    do_ret();
    // exception wins over a simultaneous return
    take_exc(1'b0, 1'b0, 1'b1);
    do_ret();
    // random mix
    for (int s = 0; s < 80; s++) begin
      if (depth == 0 || (depth < 4 && ($urandom % 2) == 1)) take_exc(1'($urandom % 2), 1'b0, 1'b0);
      else do_ret();
    end
    while (depth > 0) do_ret();
    chk(m_sp_s == SPS && m_sp_ns == SPNS, "R5", "model pointers balanced", m_sp_s, SPS);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule